// File: doc/BRIEF.md
# Keyed Reset Request Register Block

This block is a small set of memory-mapped registers for a chip's power management. It holds a reset control word, a reset status word and a watchdog word. Software reaches them over a plain 32-bit register bus with single-cycle write and read strobes. Every write must carry a fixed key in its upper byte. A write without the key is discarded and sets a sticky fault flag. A keyed write is stored with its key byte cleared.

When software writes the control register with its trigger bit set, the block issues a one-cycle request to the system. The request is either a system reset or a power-off. It is a power-off when the low twelve bits of the status register hold the halt code, and a system reset otherwise. A three-state machine produces the request pulses:

- States: `ST_IDLE` (no request), `ST_REBOOT` (system reset pulse) and `ST_HALT` (power-off pulse).
- Transition `go_reboot`: a keyed trigger write while the status code is not the halt code. It leads to `ST_REBOOT` from any state.
- Transition `go_halt`: a keyed trigger write while the status code is the halt code. It leads to `ST_HALT` from any state.
- Transition `settle`: any cycle without a trigger write. It leads back to `ST_IDLE`.

The block does not count down the watchdog value and does not sequence power. It only stores the watchdog word and raises the request pulses.

Top module: `keyed_reset_regs`

## Requirements
- R1: After reset, control reads 0x00000102, status reads 0x00001000, watchdog reads 0x00000000, `key_fault` is 0, and both request pulses are 0.
- R2: A write whose bits [31:24] are not 0x5A changes no register.
- R3: A write whose bits [31:24] equal 0x5A, to a mapped offset, stores the data with bits [31:24] forced to zero. The key never reads back.
- R4: A write whose bits [31:24] are not 0x5A sets `key_fault` in the next cycle, at any address. The flag then stays set until reset.
- R5: A keyed write to control with bit 5 set, while status bits [11:0] are not 0x555, raises `reset_pulse` for the one cycle after the write edge.
- R6: A keyed write to control with bit 5 set, while status bits [11:0] equal 0x555, raises `poweroff_pulse` for the one cycle after the write edge. Status bits above bit 11 do not affect this choice.
- R7: A keyed write to control with bit 5 clear stores the value and raises no request.
- R8: At most one request pulse is high in any cycle. Each pulse lasts one cycle unless another trigger write follows directly.
- R9: The byte offsets are control 0x1C, status 0x20 and watchdog 0x24, within a 9-bit (0x200-byte) window. Any other offset, including a misaligned one, reads zero, and a keyed write to it changes no register.
- R10: Keyed writes to status or watchdog store the value and raise no request.
- R11: `bus_rdata` is zero whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read enable, data returned in the same cycle |
| bus_addr | input | 9 | Byte offset in the window |
| bus_wdata | input | 32 | Write data; bits [31:24] carry the key |
| bus_rdata | output | 32 | Read data |
| reset_pulse | output | 1 | One-cycle system reset request |
| poweroff_pulse | output | 1 | One-cycle power-off request |
| key_fault | output | 1 | Sticky flag for a rejected write |

## Verification
The bench builds the block with its default parameters: a 9-bit window, key 0x5A in the top byte, trigger bit 5 and a 12-bit halt code of 0x555. With these values the bench can reach all three mapped offsets, an unmapped neighbour, and a misaligned offset next to the control register. It can also write a status value such as 0x1555, which differs from the halt code only above bit 11 and must still select power-off. Back-to-back trigger writes exercise the `go_reboot` and `go_halt` transitions taken directly from a pulse state rather than from `ST_IDLE`.

// File: rtl/rstkey_pkg.sv
package rstkey_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REBOOT = 2'd1,
        ST_HALT   = 2'd2
    } req_state_t;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_WDOG = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_t;

    localparam int NUM_REGS = 3;

endpackage

// File: rtl/key_gate.sv
module key_gate
    import rstkey_pkg::*;
#(
    parameter int               ADDR_W   = 9,
    parameter int               DATA_W   = 32,
    parameter int               KEY_W    = 8,
    parameter logic [KEY_W-1:0] KEY_VAL  = 8'h5A,
    parameter logic [ADDR_W-1:0] CTRL_OFF = 9'h01C,
    parameter logic [ADDR_W-1:0] STAT_OFF = 9'h020,
    parameter logic [ADDR_W-1:0] WDOG_OFF = 9'h024
) (
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output reg_sel_t          sel_o,
    output logic              wr_ok_o,
    output logic              key_bad_o,
    output logic [DATA_W-1:0] clean_o
);

    localparam int PAY_W = DATA_W - KEY_W;

    logic key_match;

    always_comb begin
        if (addr_i == CTRL_OFF)      sel_o = SEL_CTRL;
        else if (addr_i == STAT_OFF) sel_o = SEL_STAT;
        else if (addr_i == WDOG_OFF) sel_o = SEL_WDOG;
        else                         sel_o = SEL_NONE;
    end

    assign key_match = (wdata_i[DATA_W-1 -: KEY_W] == KEY_VAL);
    assign wr_ok_o   = wr_i && key_match && (sel_o != SEL_NONE);
    assign key_bad_o = wr_i && !key_match;
    assign clean_o   = {{KEY_W{1'b0}}, wdata_i[PAY_W-1:0]};

    // R2 / R4: an accepted write and a rejected write are exclusive
    always_comb begin
        assert_gate_excl_R2: assert (!(wr_ok_o && key_bad_o));
    end

endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
    parameter int                        DATA_W   = 32,
    parameter int                        KEY_W    = 8,
    parameter int                        NUM      = 3,
    parameter logic [NUM*DATA_W-1:0]     RST_VALS = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM-1:0]              we_i,
    input  logic [DATA_W-1:0]           wdata_i,
    output logic [NUM-1:0][DATA_W-1:0]  q_o
);

    // R9: at most one register is written per cycle
    assert_one_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_i));

    for (genvar i = 0; i < NUM; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       q_o[i] <= RST_VALS[i*DATA_W +: DATA_W];
            else if (we_i[i]) q_o[i] <= wdata_i;
        end

        // R2: a register without its write enable keeps its value
        assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !we_i[i] |=> $stable(q_o[i]));

        // R3: the key byte is never held in storage
        assert_no_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
            q_o[i][DATA_W-1 -: KEY_W] == '0);
    end

endmodule

// File: rtl/req_fsm.sv
module req_fsm
    import rstkey_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic halt_i,
    output logic reset_pulse_o,
    output logic poweroff_pulse_o
);

    req_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // go_reboot / go_halt from any state, settle otherwise
    always_comb begin
        if (trig_i) state_d = halt_i ? ST_HALT : ST_REBOOT;
        else        state_d = ST_IDLE;
    end

    always_comb begin
        reset_pulse_o    = 1'b0;
        poweroff_pulse_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_REBOOT: reset_pulse_o    = 1'b1;
            ST_HALT:   poweroff_pulse_o = 1'b1;
            default:   ;
        endcase
    end

    assert_reboot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && !halt_i) |=> (state_q == ST_REBOOT));

    assert_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && halt_i) |=> (state_q == ST_HALT));

    // R7 / R10: no trigger, no request in the following cycle
    assert_settle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_i |=> (state_q == ST_IDLE));

endmodule

// File: rtl/keyed_reset_regs.sv
module keyed_reset_regs
    import rstkey_pkg::*;
#(
    parameter int                ADDR_W    = 9,
    parameter int                DATA_W    = 32,
    parameter int                KEY_W     = 8,
    parameter logic [KEY_W-1:0]  KEY_VAL   = 8'h5A,
    parameter logic [ADDR_W-1:0] CTRL_OFF  = 9'h01C,
    parameter logic [ADDR_W-1:0] STAT_OFF  = 9'h020,
    parameter logic [ADDR_W-1:0] WDOG_OFF  = 9'h024,
    parameter logic [DATA_W-1:0] CTRL_RST  = 32'h0000_0102,
    parameter logic [DATA_W-1:0] STAT_RST  = 32'h0000_1000,
    parameter logic [DATA_W-1:0] WDOG_RST  = 32'h0000_0000,
    parameter int                TRIG_BIT  = 5,
    parameter int                CODE_W    = 12,
    parameter logic [CODE_W-1:0] HALT_CODE = 12'h555
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              reset_pulse,
    output logic              poweroff_pulse,
    output logic              key_fault
);

    localparam int                       IDX_CTRL = 0;
    localparam int                       IDX_STAT = 1;
    localparam int                       IDX_WDOG = 2;
    localparam logic [NUM_REGS*DATA_W-1:0] RST_VALS = {WDOG_RST, STAT_RST, CTRL_RST};

    reg_sel_t                        sel;
    logic                            wr_ok;
    logic                            key_bad;
    logic [DATA_W-1:0]               clean;
    logic [NUM_REGS-1:0]             we;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    logic                            trig;
    logic                            halt;

    key_gate #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .KEY_W   (KEY_W),
        .KEY_VAL (KEY_VAL),
        .CTRL_OFF(CTRL_OFF),
        .STAT_OFF(STAT_OFF),
        .WDOG_OFF(WDOG_OFF)
    ) u_gate (
        .wr_i     (bus_wr),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .sel_o    (sel),
        .wr_ok_o  (wr_ok),
        .key_bad_o(key_bad),
        .clean_o  (clean)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_we
        assign we[i] = wr_ok && (sel == reg_sel_t'(2'(i)));
    end

    reg_bank #(
        .DATA_W  (DATA_W),
        .KEY_W   (KEY_W),
        .NUM     (NUM_REGS),
        .RST_VALS(RST_VALS)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (we),
        .wdata_i(clean),
        .q_o    (regs)
    );

    assign trig = we[IDX_CTRL] && clean[TRIG_BIT];
    assign halt = (regs[IDX_STAT][CODE_W-1:0] == HALT_CODE);

    req_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .trig_i          (trig),
        .halt_i          (halt),
        .reset_pulse_o   (reset_pulse),
        .poweroff_pulse_o(poweroff_pulse)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       key_fault <= 1'b0;
        else if (key_bad) key_fault <= 1'b1;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                SEL_CTRL: bus_rdata = regs[IDX_CTRL];
                SEL_STAT: bus_rdata = regs[IDX_STAT];
                SEL_WDOG: bus_rdata = regs[IDX_WDOG];
                default:  bus_rdata = '0;
            endcase
        end
    end

    assert_one_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reset_pulse, poweroff_pulse}));

    assert_fault_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_wdata[DATA_W-1 -: KEY_W] != KEY_VAL)) |=> key_fault);

    assert_fault_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        key_fault |=> key_fault);

    always_comb begin
        assert_rd_idle_R11: assert (bus_rd || (bus_rdata == '0));
    end

endmodule

// File: tb/keyed_reset_regs_test.sv
`timescale 1ns/100ps
module keyed_reset_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        reset_pulse;
    logic        poweroff_pulse;
    logic        key_fault;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // behavioural reference state
    logic [31:0] m_ctrl, m_stat, m_wdog;
    bit          m_rst, m_poff, m_fault;

    always #2.5 clk = ~clk;

    keyed_reset_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .reset_pulse(reset_pulse), .poweroff_pulse(poweroff_pulse),
        .key_fault(key_fault)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = 32'h102; m_stat = 32'h1000; m_wdog = 32'h0;
            m_rst = 0; m_poff = 0; m_fault = 0;
        end else begin
            m_rst = 0; m_poff = 0;
            if (bus_wr) begin
                if (bus_wdata[31:24] != 8'h5A) m_fault = 1;
                else begin
                    case (bus_addr)
                        9'h01C: begin
                            m_ctrl = {8'h00, bus_wdata[23:0]};
                            if (bus_wdata[5]) begin
                                if (m_stat[11:0] == 12'h555) m_poff = 1;
                                else m_rst = 1;
                            end
                        end
                        9'h020: m_stat = {8'h00, bus_wdata[23:0]};
                        9'h024: m_wdog = {8'h00, bus_wdata[23:0]};
                        default: ;
                    endcase
                end
            end
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if (reset_pulse !== m_rst || poweroff_pulse !== m_poff) begin
                bad++;
                $display("FAIL R5 R6 R8 pulses: actual=%b%b expected=%b%b",
                         reset_pulse, poweroff_pulse, m_rst, m_poff);
            end
            total++;
            if (key_fault !== m_fault) begin
                bad++;
                $display("FAIL R4 key_fault: actual=%b expected=%b", key_fault, m_fault);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
        bus_rd = 1'b0;
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(9'h01C, 32'h0000_0102, "R1 ctrl reset");
        rd(9'h020, 32'h0000_1000, "R1 stat reset");
        rd(9'h024, 32'h0000_0000, "R1 wdog reset");
        chk("R1 fault reset", {31'b0, key_fault}, 32'h0);
        chk("R1 pulses reset", {30'b0, reset_pulse, poweroff_pulse}, 32'h0);

        // R2 / R4 rejected write with trigger bit
        wr(9'h01C, 32'h0000_0020);
        chk("R2 no pulse on bad key", {30'b0, reset_pulse, poweroff_pulse}, 32'h0);
        rd(9'h01C, 32'h0000_0102, "R2 ctrl unchanged");
        chk("R4 fault set", {31'b0, key_fault}, 32'h1);
        wr(9'h150, 32'hA5_123456);
        rd(9'h024, 32'h0, "R2 wdog unchanged");

        // R3 / R10 keyed stores
        wr(9'h020, 32'h5A00_0ABC);
        rd(9'h020, 32'h0000_0ABC, "R10 stat stored");
        wr(9'h024, 32'h5AFF_FFFF);
        rd(9'h024, 32'h00FF_FFFF, "R3 key stripped");

        // R7 keyed ctrl without trigger
        wr(9'h01C, 32'h5A00_00DF);
        chk("R7 no pulse", {30'b0, reset_pulse, poweroff_pulse}, 32'h0);
        rd(9'h01C, 32'h0000_00DF, "R7 ctrl stored");

        // R5 reset request
        wr(9'h01C, 32'h5A00_0020);
        chk("R5 reset pulse", {30'b0, reset_pulse, poweroff_pulse}, 32'h2);
        @(negedge clk);
        chk("R8 pulse one cycle", {30'b0, reset_pulse, poweroff_pulse}, 32'h0);

        // R6 power-off request
        wr(9'h020, 32'h5A00_0555);
        wr(9'h01C, 32'h5A00_0021);
        chk("R6 poweroff pulse", {30'b0, reset_pulse, poweroff_pulse}, 32'h1);
        wr(9'h020, 32'h5A00_1555);
        wr(9'h01C, 32'h5A00_0020);
        chk("R6 upper code bits ignored", {30'b0, reset_pulse, poweroff_pulse}, 32'h1);
        wr(9'h020, 32'h5A00_0556);
        wr(9'h01C, 32'h5A00_0020);
        chk("R5 near halt code", {30'b0, reset_pulse, poweroff_pulse}, 32'h2);

        // R8 back-to-back triggers
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 9'h01C; bus_wdata = 32'h5A00_0020;
        @(negedge clk);
        chk("R8 first pulse", {30'b0, reset_pulse, poweroff_pulse}, 32'h2);
        bus_wdata = 32'h5A00_0030;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R8 second pulse", {30'b0, reset_pulse, poweroff_pulse}, 32'h2);
        @(negedge clk);
        chk("R8 pulses end", {30'b0, reset_pulse, poweroff_pulse}, 32'h0);

        // R9 unmapped and misaligned
        wr(9'h028, 32'h5A00_0020);
        wr(9'h01D, 32'h5A00_0020);
        chk("R9 no pulse unmapped", {30'b0, reset_pulse, poweroff_pulse}, 32'h0);
        rd(9'h028, 32'h0, "R9 unmapped read");
        rd(9'h01C, 32'h0000_0030, "R9 ctrl unchanged");
        rd(9'h020, 32'h0000_0556, "R9 stat unchanged");

        // R11 idle read
        @(negedge clk);
        bus_addr = 9'h01C;
        #1;
        chk("R11 rdata idle", bus_rdata, 32'h0);

        // R4 sticky, cleared by reset
        chk("R4 fault sticky", {31'b0, key_fault}, 32'h1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 fault cleared", {31'b0, key_fault}, 32'h0);
        rd(9'h020, 32'h0000_1000, "R1 stat reset again");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule